// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one N-bit unsigned integer by another over several clock cycles. Each cycle produces one quotient bit. The partial remainder and the quotient share a single left-shifting register. The remainder sits in the upper half and the quotient enters from the bottom. Only the divisor is kept beside it, and one subtractor that is N+1 bits wide works on the upper half.

The caller loads a job with a one-cycle `start` pulse while the block is idle, and presents the operands in that same cycle. `busy` stays high while the loop runs. `done` then rises and holds the quotient and remainder steady until the next job is accepted. A zero divisor still produces a defined answer, and a flag marks it.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted, and after it, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` that is high at a clock edge while `busy` is low captures `dividend` and `divisor`. `busy` is high after that edge and `done` is low.
- R3: Count the edge that accepts `start` as edge 0. After edge N+1, `done` is high and `busy` is low, so the total is N+2 cycles.
- R4: For a nonzero divisor, the result satisfies dividend = quotient × divisor + remainder with remainder < divisor. This holds over the full unsigned range, including operands whose top bit is set.
- R5: For a zero divisor, `quotient` is all ones, `remainder` equals the dividend, and `div_by_zero` is high while `done` is high.
- R6: A `start` pulse while `busy` is high has no effect. The running job finishes with its original operands and timing.
- R7: Once `done` is high, it stays high, and `quotient`, `remainder` and `div_by_zero` hold their values until the next accepted `start`.
- R8: `busy` and `done` are never high in the same cycle.
- R9: `div_by_zero` stays low for every job whose divisor is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | N | Unsigned dividend, sampled with start |
| divisor | input | N | Unsigned divisor, sampled with start |
| busy | output | 1 | A division is in progress |
| done | output | 1 | Result valid; held until the next accepted start |
| quotient | output | N | Quotient result |
| remainder | output | N | Remainder result |
| div_by_zero | output | 1 | Result came from a zero divisor |

## Verification
The hardest case to reach is a partial remainder that needs the extra (N+1)th bit. This happens only when the divisor's top bit is set and the shifted remainder overflows N bits. The stimulus drives divisors such as 0x80000001 and 0xFFFFFFFF against all-ones and near-all-ones dividends, and adds random operands whose top bits are forced on. A second case is a `start` pulse that lands mid-run with different operands. It is injected a few cycles into a job, and the bench compares every cycle against a behavioural model that ignores that pulse.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         div_by_zero
);
  localparam int CW = $clog2(N + 1);

  logic [2*N:0]  acc;
  logic [N-1:0]  dvs;
  logic [CW-1:0] cnt;
  logic          busy_q, done_q, dz_q;

  wire [N:0]   hi     = acc[2*N:N];
  wire [N:0]   diff   = hi - {1'b0, dvs};
  wire         borrow = diff[N];
  wire [N-1:0] keep   = borrow ? hi[N-1:0] : diff[N-1:0];
  wire         accept = start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt    <= CW'(N);
      dvs    <= divisor;
      dz_q   <= (divisor == '0);
      if (divisor == '0) acc <= {dividend, 1'b0, {N{1'b1}}};
      else               acc <= {{N{1'b0}}, dividend, 1'b0};
    end else if (busy_q) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (!dz_q) acc <= {keep, acc[N-1:0], ~borrow};
      end else begin
        acc    <= {1'b0, acc[2*N:N+1], acc[N-1:0]};
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign quotient    = acc[N-1:0];
  assign remainder   = acc[2*N-1:N];
  assign div_by_zero = done_q && dz_q;

  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  a_r6_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(dvs) && $stable(dz_q));
  a_r3_final_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cnt == '0 |=> done_q && !busy_q);
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start |=> done_q && $stable(quotient) && $stable(remainder) && $stable(div_by_zero));
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !dz_q |-> remainder < dvs);
  a_r5_dz_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> quotient == {N{1'b1}});
endmodule

// File: tb/seq_divider_bench.sv
module seq_divider_bench;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] dividend = '0, divisor = '0;
  logic busy, done, div_by_zero;
  logic [N-1:0] quotient, remainder;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seq_divider #(.N(N)) u_seq_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero));

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_busy = 0, m_done = 0, m_dz = 0, m_live = 0;
  int m_left = 0;
  logic [N-1:0] m_a = '0, m_b = '0, m_q = '0, m_r = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dz = 0; m_q = '0; m_r = '0; m_live = 0;
    end else begin
      m_live = 1;
      if (!m_busy && start) begin
        m_busy = 1; m_done = 0; m_left = N + 1; m_a = dividend; m_b = divisor;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_dz = (m_b == '0);
          m_q = m_dz ? '1 : m_a / m_b;
          m_r = m_dz ? m_a : m_a % m_b;
        end
      end
    end
  end

  always @(negedge clk) if (m_live && !finished) begin
    chk(busy == m_busy, "R2/R3 busy", N'(busy), N'(m_busy));
    chk(done == m_done, "R3/R7 done", N'(done), N'(m_done));
    chk(!(busy && done), "R8 busy&done", N'(busy), 0);
    if (!m_busy) begin
      chk(quotient == m_q, m_dz ? "R5 quotient" : "R4 quotient", quotient, m_q);
      chk(remainder == m_r, m_dz ? "R5 remainder" : "R4 remainder", remainder, m_r);
      chk(div_by_zero == (m_done && m_dz), m_dz ? "R5 flag" : "R9 flag",
          N'(div_by_zero), N'(m_done && m_dz));
    end
  end

  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input int idle);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0; dividend = $urandom; divisor = $urandom;
    repeat (N + 1 + idle) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    chk(!busy && !done && !div_by_zero, "R1 flags in reset", {busy, done, div_by_zero}, 0);
    chk(quotient == '0 && remainder == '0, "R1 data in reset", quotient | remainder, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'd100, 32'd7, 0);
    run(32'hFFFFFFFF, 32'd1, 2);
    run(32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    run(32'hFFFFFFFE, 32'hFFFFFFFF, 1);
    run(32'hFFFFFFFF, 32'h80000001, 0);
    run(32'h80000000, 32'd3, 0);
    run(32'd5, 32'd9, 3);
    run(32'h12345678, 32'd0, 4);   // R5
    run(32'd0, 32'd0, 0);          // R5
    run(32'd0, 32'd17, 0);
    // R6: a start while busy with other operands is ignored
    @(negedge clk);
    start = 1'b1; dividend = 32'd1000; divisor = 32'd33;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; dividend = 32'd7; divisor = 32'd0;
    @(negedge clk); start = 1'b0;
    repeat (N + 2) @(negedge clk);
    chk(quotient == 32'd30 && remainder == 32'd10, "R6 ignored start", quotient, 32'd30);
    // R7: result held over idle cycles
    repeat (10) @(negedge clk);
    chk(done && quotient == 32'd30, "R7 hold", quotient, 32'd30);
    for (int i = 0; i < 300; i++) begin
      logic [N-1:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 3 == 0) b[N-1] = 1'b1;
      if (i % 4 == 0) a[N-1] = 1'b1;
      if (i % 5 == 0) b = b >> (i % 31);
      run(a, b, i % 3);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule